// File: doc/BRIEF.md
# SDRAM Open-Page Tracker

This block keeps a table of the SDRAM pages that a memory controller currently holds open on one SDR channel, and classifies each incoming access against that table. For a request naming a physical row (chip select), a bank and an address, it answers one clock later with one of three outcomes. A hit means the addressed page is already open in that bank. An empty result means the bank has nothing open. A conflict means another page sits open in that bank and has to be precharged first.

The controller keeps the table current through three kinds of notification: a page was activated, a bank was precharged, or every bank of a row was precharged at once. Each row has its own page size. The size sets which address bits form the page number that the table stores and compares. Two neighbouring rows make up one double-sided module. Each module may hold only a limited number of open pages. When an activation would exceed that cap, the tracker drops the page in that module that was opened longest ago. It then names that page on a close-request output so the controller can issue the matching precharge.

The tracker issues no SDRAM commands. It does not schedule refresh and it does not enforce timing parameters. Row and bank counts are powers of two per module, and rows `2k` and `2k+1` form module `k`.

Top module: `page_track`

## Requirements
- R1: The page number of an address is `addr >> (11 + code)`, where `code` is the 2-bit field `row_page_size[2*r+1:2*r]` of the addressed row `r`. Code 0 selects 2 KB, code 1 selects 4 KB, code 2 selects 8 KB and code 3 selects 16 KB. Address bits below the page boundary never change a result.
- R2: One cycle after `req_valid`, `rsp_valid` is 1 and `rsp_class` is 0 (hit), 1 (empty) or 2 (conflict). The class is judged against the table as it stood before that cycle's update. Without a request, `rsp_valid` is 0 in the next cycle.
- R3: An open notification records the page in the named row and bank. Opening a bank that is already open replaces its page, and that page becomes the most recently opened one in its module.
- R4: A close notification removes the named bank's entry. Closing a bank that holds no page has no effect on the table.
- R5: A precharge-all notification empties every bank of the named row in one cycle and leaves all other rows untouched.
- R6: Rows `2k` and `2k+1` share module `k`, and no module ever holds more than `DIMM_LIMIT` open pages.
- R7: When a page is opened in a bank holding nothing while its module already holds `DIMM_LIMIT` pages, the page opened longest ago in that module is removed. One cycle later `close_req_valid` pulses with that page's row and bank. At no other time does `close_req_valid` rise.
- R8: Only one notification takes effect per cycle. Precharge-all wins over close, and close wins over open; the losing notifications are dropped.
- R9: After reset no page is open, and `rsp_valid` and `close_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_page_size | input | 2*NUM_ROWS | Page-size code per row, 2 bits each |
| req_valid | input | 1 | Classification request |
| req_row | input | ROW_W | Row of the request |
| req_bank | input | BANK_W | Bank of the request |
| req_addr | input | ADDR_W | Address of the request |
| rsp_valid | output | 1 | Classification result valid |
| rsp_class | output | 2 | 0 hit, 1 empty, 2 conflict |
| open_valid | input | 1 | Page-activated notification |
| open_row | input | ROW_W | Row of the activation |
| open_bank | input | BANK_W | Bank of the activation |
| open_addr | input | ADDR_W | Address of the opened page |
| close_valid | input | 1 | Bank-precharged notification |
| close_row | input | ROW_W | Row of the precharge |
| close_bank | input | BANK_W | Bank of the precharge |
| pall_valid | input | 1 | Row-wide precharge notification |
| pall_row | input | ROW_W | Row precharged entirely |
| close_req_valid | output | 1 | Oldest page of a full module must be closed |
| close_req_row | output | ROW_W | Row of that page |
| close_req_bank | output | BANK_W | Bank of that page |

## Verification
Some properties are checked on every cycle. A response follows every request one cycle later, and a response never carries the unused class code. No module exceeds its page cap. A close request appears only after a cycle whose winning notification was an open. A row precharged one cycle earlier always answers empty.

Some behaviour can only be shown by the bench's scenarios, checked against its own timestamped model of the table. This covers page-boundary masking for all four sizes on every row, and replacement on reopen. It also covers exactly which page is chosen as oldest after reopens and removals, and the dropping of lower-priority notifications.

// File: rtl/page_track_pkg.sv
package page_track_pkg;

    // Classification codes reported on rsp_class
    typedef enum logic [1:0] {
        PC_HIT      = 2'd0,
        PC_EMPTY    = 2'd1,
        PC_CONFLICT = 2'd2
    } page_class_e;

    // Smallest page is 2 KB
    localparam int unsigned MIN_PAGE_SHIFT = 11;

endpackage

// File: rtl/page_track_key.sv
module page_track_key #(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        size_code,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] key
);
    // Page number: drop the in-page offset for the selected size
    assign key = addr >> (5'(page_track_pkg::MIN_PAGE_SHIFT) + 5'(size_code));
endmodule

// File: rtl/page_track_dimm.sv
module page_track_dimm #(
    parameter int ROWS_PER = 2,
    parameter int BANKS    = 4,
    parameter int LIMIT    = 8,
    parameter int ADDR_W   = 32,
    localparam int SLOTS   = ROWS_PER * BANKS,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int LROW_W  = (ROWS_PER > 1) ? $clog2(ROWS_PER) : 1,
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pall_en,
    input  logic [LROW_W-1:0] pall_lrow,
    input  logic              close_en,
    input  logic [SLOT_W-1:0] close_slot,
    input  logic              open_en,
    input  logic [SLOT_W-1:0] open_slot,
    input  logic [ADDR_W-1:0] open_key,
    input  logic [SLOT_W-1:0] lk_slot,
    output logic              lk_valid,
    output logic [ADDR_W-1:0] lk_key,
    output logic              evict_valid,
    output logic [SLOT_W-1:0] evict_slot,
    output logic [CNT_W-1:0]  occupancy
);
    logic [SLOTS-1:0]  vld_q, vld_d, rm, ins;
    logic [SLOT_W-1:0] rank_q [SLOTS];
    logic [SLOT_W-1:0] rank_d [SLOTS];
    logic [ADDR_W-1:0] key_q  [SLOTS];
    logic [ADDR_W-1:0] key_d  [SLOTS];
    logic [CNT_W-1:0]  keep_cnt;

    assign lk_valid = vld_q[lk_slot];
    assign lk_key   = key_q[lk_slot];

    // Occupancy and oldest entry (age rank 0)
    always_comb begin
        occupancy  = '0;
        evict_slot = '0;
        for (int i = 0; i < SLOTS; i++) begin
            occupancy = occupancy + CNT_W'(vld_q[i]);
            if (vld_q[i] && rank_q[i] == '0) evict_slot = SLOT_W'(i);
        end
    end

    // One notification per cycle: removal mask plus optional insert
    always_comb begin
        rm          = '0;
        ins         = '0;
        evict_valid = 1'b0;
        if (pall_en) begin
            for (int b = 0; b < BANKS; b++) begin
                rm[SLOT_W'(int'(pall_lrow) * BANKS + b)] = vld_q[SLOT_W'(int'(pall_lrow) * BANKS + b)];
            end
        end else if (close_en) begin
            rm[close_slot] = vld_q[close_slot];
        end else if (open_en) begin
            ins[open_slot] = 1'b1;
            if (vld_q[open_slot]) begin
                rm[open_slot] = 1'b1;
            end else if (int'(occupancy) >= LIMIT) begin
                rm[evict_slot] = 1'b1;
                evict_valid    = 1'b1;
            end
        end
    end

    // Compact age ranks around removed entries, append insert as youngest
    always_comb begin
        keep_cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            keep_cnt = keep_cnt + CNT_W'(vld_q[i] & ~rm[i]);
        end
        for (int i = 0; i < SLOTS; i++) begin
            logic [SLOT_W-1:0] drop;
            drop = '0;
            for (int j = 0; j < SLOTS; j++) begin
                if (rm[j] && rank_q[j] < rank_q[i]) drop = drop + SLOT_W'(1);
            end
            vld_d[i]  = (vld_q[i] & ~rm[i]) | ins[i];
            rank_d[i] = rank_q[i] - drop;
            key_d[i]  = key_q[i];
            if (ins[i]) begin
                rank_d[i] = SLOT_W'(keep_cnt);
                key_d[i]  = open_key;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                rank_q[i] <= '0;
                key_q[i]  <= '0;
            end
        end else begin
            vld_q <= vld_d;
            for (int i = 0; i < SLOTS; i++) begin
                rank_q[i] <= rank_d[i];
                key_q[i]  <= key_d[i];
            end
        end
    end
endmodule

// File: rtl/page_track.sv
module page_track #(
    parameter int NUM_ROWS   = 6,
    parameter int BANKS      = 4,
    parameter int DIMM_LIMIT = 8,
    parameter int ADDR_W     = 32,
    localparam int ROW_W     = $clog2(NUM_ROWS),
    localparam int BANK_W    = $clog2(BANKS),
    localparam int DIM_W     = ROW_W - 1,
    localparam int NUM_DIMMS = NUM_ROWS / 2,
    localparam int SLOT_W    = 1 + BANK_W,
    localparam int CNT_W     = $clog2(2 * BANKS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NUM_ROWS-1:0] row_page_size,
    input  logic                  req_valid,
    input  logic [ROW_W-1:0]      req_row,
    input  logic [BANK_W-1:0]     req_bank,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_class,
    input  logic                  open_valid,
    input  logic [ROW_W-1:0]      open_row,
    input  logic [BANK_W-1:0]     open_bank,
    input  logic [ADDR_W-1:0]     open_addr,
    input  logic                  close_valid,
    input  logic [ROW_W-1:0]      close_row,
    input  logic [BANK_W-1:0]     close_bank,
    input  logic                  pall_valid,
    input  logic [ROW_W-1:0]      pall_row,
    output logic                  close_req_valid,
    output logic [ROW_W-1:0]      close_req_row,
    output logic [BANK_W-1:0]     close_req_bank
);
    import page_track_pkg::*;

    logic [1:0]        req_size, open_size;
    logic [ADDR_W-1:0] req_key, open_key;
    page_class_e       lk_cls;

    logic                                lk_vld  [NUM_DIMMS];
    logic [ADDR_W-1:0]                   lk_key  [NUM_DIMMS];
    logic                                ev_vld  [NUM_DIMMS];
    logic [SLOT_W-1:0]                   ev_slot [NUM_DIMMS];
    logic [NUM_DIMMS-1:0][CNT_W-1:0]     dimm_occ;

    // Per-row page size lookup
    always_comb begin
        req_size  = 2'd0;
        open_size = 2'd0;
        for (int i = 0; i < NUM_ROWS; i++) begin
            if (req_row  == ROW_W'(i)) req_size  = row_page_size[2*i +: 2];
            if (open_row == ROW_W'(i)) open_size = row_page_size[2*i +: 2];
        end
    end

    page_track_key #(.ADDR_W(ADDR_W)) u_req_key (
        .size_code(req_size), .addr(req_addr), .key(req_key)
    );
    page_track_key #(.ADDR_W(ADDR_W)) u_open_key (
        .size_code(open_size), .addr(open_addr), .key(open_key)
    );

    for (genvar d = 0; d < NUM_DIMMS; d++) begin : g_dimm
        page_track_dimm #(
            .ROWS_PER(2), .BANKS(BANKS), .LIMIT(DIMM_LIMIT), .ADDR_W(ADDR_W)
        ) u_dimm (
            .clk         (clk),
            .rst_n       (rst_n),
            .pall_en     (pall_valid && pall_row[ROW_W-1:1] == DIM_W'(d)),
            .pall_lrow   (pall_row[0]),
            .close_en    (!pall_valid && close_valid && close_row[ROW_W-1:1] == DIM_W'(d)),
            .close_slot  ({close_row[0], close_bank}),
            .open_en     (!pall_valid && !close_valid && open_valid &&
                          open_row[ROW_W-1:1] == DIM_W'(d)),
            .open_slot   ({open_row[0], open_bank}),
            .open_key    (open_key),
            .lk_slot     ({req_row[0], req_bank}),
            .lk_valid    (lk_vld[d]),
            .lk_key      (lk_key[d]),
            .evict_valid (ev_vld[d]),
            .evict_slot  (ev_slot[d]),
            .occupancy   (dimm_occ[d])
        );
    end

    // Classify against the current table
    always_comb begin
        lk_cls = PC_EMPTY;
        for (int d = 0; d < NUM_DIMMS; d++) begin
            if (req_row[ROW_W-1:1] == DIM_W'(d) && lk_vld[d]) begin
                lk_cls = (lk_key[d] == req_key) ? PC_HIT : PC_CONFLICT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_class       <= PC_EMPTY;
            close_req_valid <= 1'b0;
            close_req_row   <= '0;
            close_req_bank  <= '0;
        end else begin
            rsp_valid       <= req_valid;
            rsp_class       <= lk_cls;
            close_req_valid <= 1'b0;
            for (int d = 0; d < NUM_DIMMS; d++) begin
                if (ev_vld[d]) begin
                    close_req_valid <= 1'b1;
                    close_req_row   <= {DIM_W'(d), ev_slot[d][SLOT_W-1]};
                    close_req_bank  <= ev_slot[d][BANK_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/page_track_chk.sv
module page_track_chk #(
    parameter int NUM_ROWS   = 6,
    parameter int DIMM_LIMIT = 8,
    parameter int ROW_W      = 3,
    parameter int NUM_DIMMS  = 3,
    parameter int CNT_W      = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic [ROW_W-1:0]              req_row,
    input logic                          rsp_valid,
    input logic [1:0]                    rsp_class,
    input logic                          open_valid,
    input logic                          close_valid,
    input logic                          pall_valid,
    input logic [ROW_W-1:0]              pall_row,
    input logic                          close_req_valid,
    input logic [ROW_W-1:0]              close_req_row,
    input logic [NUM_DIMMS-1:0][CNT_W-1:0] dimm_occ
);
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r2_class_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_class != 2'd3);
    a_r5_pall_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pall_valid) && req_valid && req_row == $past(pall_row)) |=> rsp_class == 2'd1);
    a_r8_close_req_from_open: assert property (@(posedge clk) disable iff (!rst_n)
        close_req_valid |-> $past(open_valid && !close_valid && !pall_valid));
    a_r7_close_req_row: assert property (@(posedge clk) disable iff (!rst_n)
        close_req_valid |-> int'(close_req_row) < NUM_ROWS);
    for (genvar d = 0; d < NUM_DIMMS; d++) begin : g_cap
        a_r6_dimm_cap: assert property (@(posedge clk) disable iff (!rst_n)
            int'(dimm_occ[d]) <= DIMM_LIMIT);
    end
endmodule

bind page_track page_track_chk #(
    .NUM_ROWS(NUM_ROWS), .DIMM_LIMIT(DIMM_LIMIT), .ROW_W(ROW_W),
    .NUM_DIMMS(NUM_DIMMS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .rsp_valid(rsp_valid), .rsp_class(rsp_class), .open_valid(open_valid),
    .close_valid(close_valid), .pall_valid(pall_valid), .pall_row(pall_row),
    .close_req_valid(close_req_valid), .close_req_row(close_req_row),
    .dimm_occ(dimm_occ)
);

// File: tb/page_track_bench.sv
`timescale 1ns/1ps
module page_track_bench;
    localparam int ROWS = 6, BANKS = 4, LIM = 3, AW = 20;

    logic clk = 0, rst_n = 0;
    logic [2*ROWS-1:0] row_page_size = '0;
    logic req_valid = 0, open_valid = 0, close_valid = 0, pall_valid = 0;
    logic [2:0] req_row = 0, open_row = 0, close_row = 0, pall_row = 0;
    logic [1:0] req_bank = 0, open_bank = 0, close_bank = 0;
    logic [AW-1:0] req_addr = 0, open_addr = 0;
    logic rsp_valid, close_req_valid;
    logic [1:0] rsp_class, close_req_bank;
    logic [2:0] close_req_row;

    int checks = 0, errors = 0;
    bit done = 0;

    // Model of the table
    int m_vld [ROWS][BANKS];
    int m_key [ROWS][BANKS];
    int m_stamp [ROWS][BANKS];
    int sz [ROWS];
    int stamp_ctr = 0;

    always #2 clk = ~clk;

    page_track #(.NUM_ROWS(ROWS), .BANKS(BANKS), .DIMM_LIMIT(LIM), .ADDR_W(AW)) u_page_track (.*);

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int key_of(int row, int addr);
        return addr >> (11 + sz[row]);
    endfunction

    function automatic int exp_class(int row, int bank, int addr);
        if (m_vld[row][bank] == 0) return 1;
        return (m_key[row][bank] == key_of(row, addr)) ? 0 : 2;
    endfunction

    task automatic set_sizes();
        for (int r = 0; r < ROWS; r++) row_page_size[2*r +: 2] = 2'(sz[r]);
    endtask

    task automatic do_req(int row, int bank, int addr, string tag);
        int e;
        e = exp_class(row, bank, addr);
        req_valid = 1; req_row = 3'(row); req_bank = 2'(bank); req_addr = AW'(addr);
        @(negedge clk);
        chk(rsp_valid == 1, tag, int'(rsp_valid), 1);
        chk(int'(rsp_class) == e, tag, int'(rsp_class), e);
        req_valid = 0;
    endtask

    task automatic model_remove(int row, int bank);
        m_vld[row][bank] = 0;
    endtask

    task automatic do_open(int row, int bank, int addr, string tag);
        int cnt, er, eb, best, ev;
        ev = 0; er = 0; eb = 0;
        if (m_vld[row][bank] == 0) begin
            cnt = 0; best = 32'h7fffffff;
            for (int r = (row/2)*2; r < (row/2)*2 + 2; r++)
                for (int b = 0; b < BANKS; b++)
                    if (m_vld[r][b] != 0) begin
                        cnt++;
                        if (m_stamp[r][b] < best) begin best = m_stamp[r][b]; er = r; eb = b; end
                    end
            if (cnt >= LIM) ev = 1;
        end
        open_valid = 1; open_row = 3'(row); open_bank = 2'(bank); open_addr = AW'(addr);
        @(negedge clk);
        chk(int'(close_req_valid) == ev, tag, int'(close_req_valid), ev);
        if (ev == 1) begin
            chk(int'(close_req_row) == er, tag, int'(close_req_row), er);
            chk(int'(close_req_bank) == eb, tag, int'(close_req_bank), eb);
            model_remove(er, eb);
        end
        open_valid = 0;
        m_vld[row][bank] = 1;
        m_key[row][bank] = key_of(row, addr);
        m_stamp[row][bank] = stamp_ctr++;
    endtask

    task automatic do_close(int row, int bank);
        close_valid = 1; close_row = 3'(row); close_bank = 2'(bank);
        @(negedge clk);
        close_valid = 0;
        model_remove(row, bank);
    endtask

    task automatic do_pall(int row);
        pall_valid = 1; pall_row = 3'(row);
        @(negedge clk);
        pall_valid = 0;
        for (int b = 0; b < BANKS; b++) model_remove(row, b);
    endtask

    task automatic sweep(string tag);
        for (int r = 0; r < ROWS; r++)
            for (int b = 0; b < BANKS; b++)
                do_req(r, b, 20'h5A000 + r * 20'h800, tag);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            sz[r] = 0;
            for (int b = 0; b < BANKS; b++) begin m_vld[r][b] = 0; m_key[r][b] = 0; m_stamp[r][b] = 0; end
        end
        set_sizes();
        repeat (3) @(negedge clk);
        // R9: outputs quiet after reset, nothing open
        chk(rsp_valid == 0, "R9 rsp_valid", int'(rsp_valid), 0);
        chk(close_req_valid == 0, "R9 close_req_valid", int'(close_req_valid), 0);
        rst_n = 1;
        @(negedge clk);
        sweep("R9 empty after reset");

        // R1: page boundary per size code, every row
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < ROWS; r++) sz[r] = (s + r) % 4;
            set_sizes();
            for (int r = 0; r < ROWS; r++) do_pall(r);
            for (int r = 0; r < ROWS; r++) begin
                int base, sh;
                base = 20'h5A000;
                sh = 11 + sz[r];
                do_open(r, r % 4, base, "R1 open");
                do_req(r, r % 4, base | ((1 << sh) - 1), "R1 low bits ignored");
                do_req(r, r % 4, base ^ (1 << (sh - 1)), "R1 below boundary");
                do_req(r, r % 4, base ^ (1 << sh), "R1 boundary bit conflict");
                do_req(r, (r + 1) % 4, base, "R2 empty bank");
            end
        end

        // R3: reopen replaces page
        do_pall(0); do_pall(1);
        do_open(0, 1, 20'h10000, "R3 open");
        do_open(0, 1, 20'h24000, "R3 reopen");
        do_req(0, 1, 20'h10000, "R3 old page conflicts");
        do_req(0, 1, 20'h24000, "R3 new page hits");

        // R4: close, and close of an empty bank
        do_open(0, 2, 20'h30000, "R4 open");
        do_close(0, 2);
        do_req(0, 2, 20'h30000, "R4 closed bank empty");
        do_close(1, 3);
        do_req(0, 1, 20'h24000, "R4 empty close no effect");
        do_req(1, 3, 20'h24000, "R4 empty close stays empty");

        // R7 / R6: eviction of oldest, reopen refreshes age
        do_pall(2); do_pall(3);
        do_open(2, 0, 20'h01000, "R7 fill");
        do_open(3, 1, 20'h02000, "R7 fill");
        do_open(2, 2, 20'h03000, "R7 fill");
        do_open(3, 3, 20'h04000, "R7 evict oldest");
        do_open(3, 1, 20'h05000, "R7 reopen refreshes age");
        do_open(2, 1, 20'h06000, "R7 evict after reorder");
        do_close(3, 3);
        do_open(2, 3, 20'h07000, "R7 no evict below cap");
        do_open(3, 0, 20'h08000, "R7 evict after close");
        sweep("R6 table after evictions");

        // R5: precharge-all clears one row only
        do_pall(4); do_pall(5);
        do_open(4, 0, 20'h11000, "R5 open");
        do_open(4, 3, 20'h12000, "R5 open");
        do_open(5, 2, 20'h13000, "R5 open");
        do_pall(4);
        for (int b = 0; b < BANKS; b++) do_req(4, b, 20'h11000, "R5 row cleared");
        do_req(5, 2, 20'h13000, "R5 neighbour kept");

        // R8: precharge-all beats open in the same cycle
        pall_valid = 1; pall_row = 3'd5; open_valid = 1; open_row = 3'd4; open_bank = 2'd1;
        open_addr = 20'h15000;
        @(negedge clk);
        chk(close_req_valid == 0, "R8 no close req", int'(close_req_valid), 0);
        pall_valid = 0; open_valid = 0;
        for (int b = 0; b < BANKS; b++) model_remove(5, b);
        do_req(4, 1, 20'h15000, "R8 open dropped under pall");
        do_req(5, 2, 20'h13000, "R8 pall applied");
        // close beats open
        do_open(4, 2, 20'h16000, "R8 setup");
        close_valid = 1; close_row = 3'd4; close_bank = 2'd2;
        open_valid = 1; open_row = 3'd5; open_bank = 2'd0; open_addr = 20'h17000;
        @(negedge clk);
        close_valid = 0; open_valid = 0;
        model_remove(4, 2);
        do_req(4, 2, 20'h16000, "R8 close applied");
        do_req(5, 0, 20'h17000, "R8 open dropped under close");

        // R2: request sees table before same-cycle update
        req_valid = 1; req_row = 3'd5; req_bank = 2'd3; req_addr = 20'h19000;
        open_valid = 1; open_row = 3'd5; open_bank = 2'd3; open_addr = 20'h19000;
        @(negedge clk);
        chk(int'(rsp_class) == 1, "R2 pre-update class", int'(rsp_class), 1);
        req_valid = 0; open_valid = 0;
        m_vld[5][3] = 1; m_key[5][3] = key_of(5, 20'h19000); m_stamp[5][3] = stamp_ctr++;
        do_req(5, 3, 20'h19000, "R2 post-update hit");
        @(negedge clk);
        chk(rsp_valid == 0, "R2 no rsp without req", int'(rsp_valid), 0);
        sweep("R2 final table");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule